// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit guards every programming operation of a serial memory. It keeps the write enable latch and three persistent protection bits: a pin-lock enable and a two-bit block protection level. The command decoder in front of it raises one-cycle strobes for set-latch, clear-latch, status write and array write. The unit then decides whether each write may go ahead, using the target address, the protection level, the write-protect pin and the pin-lock enable bit.

An accepted write starts an internal programming cycle. Here that cycle is modelled as a busy period of `BUSY_CYCLES` clocks. When the period ends, the latch clears on its own. The unit also builds the status byte for readback. This byte reads as all ones while a programming cycle is running.

Top module: `write_guard`

## Requirements
- R1: After reset the latch, the pin-lock enable and both protection bits are 0, `busy` and `grant` are low, and `statusByte` is 8'h00.
- R2: When idle, `cmdSetWel` sets the latch and `cmdClrWel` clears it. If both strobes are high together, clear wins. Clearing works whatever the level of `wpPin`.
- R3: A status write or an array write made while the latch is 0 is refused.
- R4: Array writes are refused inside the protected range, whatever the level of `wpPin`. The range depends on address bits [15:14] and the level {bp1,bp0}: 00 protects nothing, 01 protects addresses with [15:14]=11 (C000-FFFF), 10 protects addresses with bit 15 set (8000-FFFF), and 11 protects all addresses.
- R5: A status write is refused while `wpPin` is low and the pin-lock enable is 1. It is allowed while `wpPin` is high or the enable is 0.
- R6: An accepted status write loads the pin-lock enable from `dataIn[7]` and {bp1,bp0} from `dataIn[3:2]`. All other data bits are ignored.
- R7: An accepted write gives a one-cycle `grant` pulse in the cycle after the strobe. `busy` goes high in that same cycle and stays high for exactly `BUSY_CYCLES` cycles.
- R8: When idle, `statusByte` is {enable, 0, 0, 0, bp1, bp0, latch, 0}. While busy it is 8'hFF.
- R9: The latch clears when the busy period ends.
- R10: A refused write gives no grant and starts no busy period. It leaves the latch and the protection bits unchanged.
- R11: All strobes are ignored while busy. They give no grant and do not extend the busy period.
- R12: If several strobes come in the same idle cycle, the priority is clear, then set, then status write, then array write. Only the highest-priority strobe is acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdSetWel | input | 1 | Strobe: set the write enable latch |
| cmdClrWel | input | 1 | Strobe: clear the write enable latch |
| cmdStatWr | input | 1 | Strobe: status write request |
| cmdArrWr | input | 1 | Strobe: array write request |
| addr | input | 16 | Target address of an array write |
| dataIn | input | 8 | Data byte of a status write |
| wpPin | input | 1 | Write-protect pin, active low |
| grant | output | 1 | One-cycle pulse when a write is accepted |
| busy | output | 1 | High during the programming cycle |
| statusByte | output | 8 | Status byte for readback |

## Verification
The bench builds the unit with `BUSY_CYCLES` set to 4. With this value every busy period, and the clearing of the latch at its end, fits in a few cycles. Strobes can then also be placed on the first and last busy cycles to show they are ignored. The address width stays at 16. This keeps the boundaries of every protection level reachable at their real addresses (7FFF/8000, BFFF/C000, 0000).

// File: rtl/write_guard_pkg.sv
`timescale 1ns/1ps
package write_guard_pkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
    logic endCycle;
  } dpStrobe_t;

  // persistent state the control needs for its decisions
  typedef struct packed {
    logic       wel;
    logic       wpen;
    logic [1:0] bp;
  } guardState_t;

  // is an address with these two top bits inside the protected range
  function automatic logic inProtRange(input logic [1:0] level, input logic [1:0] topBits);
    logic hit;
    case (level)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (topBits == 2'b11);
      2'b10:   hit = topBits[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/write_guard_ctrl.sv
`timescale 1ns/1ps
module write_guard_ctrl
  import write_guard_pkg::*;
#(
  parameter int BUSY_CYCLES = 5000,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              cmdStatWr,
  input  logic              cmdArrWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wpPin,
  input  guardState_t       st,
  output dpStrobe_t         strobe,
  output logic              grant,
  output logic              busy
);

  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic idle, hwLock, arrBlocked, noLatchCmd;
  logic statOk, arrOk, accept, cycleDone;
  logic unusedAddr;

  assign unusedAddr = ^addr[ADDR_W-3:0];

  always_comb begin
    idle       = !busy;
    hwLock     = !wpPin && st.wpen;
    arrBlocked = inProtRange(st.bp, addr[ADDR_W-1 -: 2]);
    noLatchCmd = !cmdClrWel && !cmdSetWel;
    statOk     = idle && noLatchCmd && cmdStatWr && st.wel && !hwLock;
    arrOk      = idle && noLatchCmd && !cmdStatWr && cmdArrWr && st.wel && !arrBlocked;
    accept     = statOk || arrOk;
    cycleDone  = busy && (cnt == '0);

    strobe.clrWel   = idle && cmdClrWel;
    strobe.setWel   = idle && !cmdClrWel && cmdSetWel;
    strobe.loadStat = statOk;
    strobe.endCycle = cycleDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grant <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      grant <= accept;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> grant);

  // R11
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !grant);

  // R3
  no_latch_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdArrWr && !cmdStatWr && !st.wel) |=> !grant);

  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdArrWr && !cmdStatWr && st.bp == 2'b11) |=> !grant);

  // R5
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStatWr && !wpPin && st.wpen) |=> !grant);

endmodule

// File: rtl/write_guard_dp.sv
`timescale 1ns/1ps
module write_guard_dp
  import write_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [7:0]  dataIn,
  input  logic        busy,
  output guardState_t st,
  output logic [7:0]  statusByte
);

  logic       wel, wpen;
  logic [1:0] bp;
  logic       unusedData;

  assign unusedData = ^{dataIn[6:4], dataIn[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel  <= 1'b0;
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else begin
      if (strobe.clrWel || strobe.endCycle) wel <= 1'b0;
      else if (strobe.setWel)               wel <= 1'b1;
      if (strobe.loadStat) begin
        wpen <= dataIn[7];
        bp   <= dataIn[3:2];
      end
    end
  end

  always_comb begin
    st.wel  = wel;
    st.wpen = wpen;
    st.bp   = bp;
    if (busy) statusByte = 8'hFF;
    else      statusByte = {wpen, 3'b000, bp, wel, 1'b0};
  end

  // R9
  wel_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R2
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrWel |=> !wel);

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStat |=> $stable({wpen, bp}));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (statusByte[6:4] == 3'b000 && !statusByte[0]));

endmodule

// File: rtl/write_guard.sv
`timescale 1ns/1ps
module write_guard
  import write_guard_pkg::*;
#(
  parameter int BUSY_CYCLES = 5000,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              cmdStatWr,
  input  logic              cmdArrWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              wpPin,
  output logic              grant,
  output logic              busy,
  output logic [7:0]        statusByte
);

  dpStrobe_t   strobe;
  guardState_t st;

  write_guard_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel),
    .cmdStatWr(cmdStatWr), .cmdArrWr(cmdArrWr),
    .addr(addr), .wpPin(wpPin), .st(st),
    .strobe(strobe), .grant(grant), .busy(busy)
  );

  write_guard_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .busy(busy), .st(st), .statusByte(statusByte)
  );

endmodule

// File: tb/sim_write_guard.sv
`timescale 1ns/1ps
module sim_write_guard;

  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdSetWel = 0, cmdClrWel = 0, cmdStatWr = 0, cmdArrWr = 0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        wpPin = 1'b1;
  logic        grant, busy;
  logic [7:0]  statusByte;

  int checks = 0;
  int errors = 0;

  logic [9:0] expQ[$];
  string      tagQ[$];

  int       mCnt = 0;
  bit       mWel = 0, mWpen = 0;
  bit [1:0] mBp = 0;

  always #10 clk = ~clk;

  write_guard #(.BUSY_CYCLES(BUSY), .ADDR_W(16)) u0 (
    .clk(clk), .rstN(rstN),
    .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel),
    .cmdStatWr(cmdStatWr), .cmdArrWr(cmdArrWr),
    .addr(addr), .dataIn(dataIn), .wpPin(wpPin),
    .grant(grant), .busy(busy), .statusByte(statusByte)
  );

  function automatic bit prot(bit [1:0] lvl, bit [15:0] a);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return a[15:14] == 2'b11;
      2'b10:   return a[15];
      default: return 1'b1;
    endcase
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input bit s, input bit c, input bit sw, input bit aw,
                      input bit [15:0] a, input bit [7:0] d, input bit wp, input string tag);
    bit acc;
    bit [7:0] st;
    @(negedge clk);
    cmdSetWel = s; cmdClrWel = c; cmdStatWr = sw; cmdArrWr = aw;
    addr = a; dataIn = d; wpPin = wp;
    acc = 0;
    if (mCnt > 0) begin
      mCnt--;
      if (mCnt == 0) mWel = 0;
    end else if (c) mWel = 0;
    else if (s) mWel = 1;
    else if (sw) begin
      if (mWel && !(!wp && mWpen)) begin
        acc = 1; mWpen = d[7]; mBp = d[3:2]; mCnt = BUSY;
      end
    end else if (aw && mWel && !prot(mBp, a)) begin
      acc = 1; mCnt = BUSY;
    end
    st = (mCnt > 0) ? 8'hFF : {mWpen, 3'b000, mBp, mWel, 1'b0};
    expQ.push_back({acc, mCnt > 0, st});
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n, input bit wp, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 16'h0000, 8'h00, wp, tag);
  endtask

  // monitor: compares outputs just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [9:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({grant, busy, statusByte} !== e) begin
          errors++;
          $display("FAIL %s actual grant=%0b busy=%0b status=%02h expected grant=%0b busy=%0b status=%02h",
                   t, grant, busy, statusByte, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (grant !== 1'b0 || busy !== 1'b0 || statusByte !== 8'h00) begin
      errors++;
      $display("FAIL R1 actual grant=%0b busy=%0b status=%02h expected 0 0 00", grant, busy, statusByte);
    end
    @(negedge clk);
    rstN = 1'b1;

    step(0, 0, 0, 1, 16'h0000, 8'h00, 1, "R3 array write without latch");
    step(0, 0, 1, 0, 16'h0000, 8'h8C, 1, "R3 status write without latch");
    step(1, 1, 0, 0, 16'h0000, 8'h00, 1, "R2 R12 clear wins over set");
    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 1, 0, 0, 16'h0000, 8'h00, 0, "R2 clear with pin low");
    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 0, 1, 16'h1234, 8'h00, 1, "R7 array write accepted");
    idle(BUSY, 1, "R7 R9 busy period and latch clear");

    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 1, 0, 16'h0000, 8'hFF, 1, "R6 status write ignores other bits");
    idle(BUSY, 1, "R8 R6 status after load");

    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 0, 1, 16'h0000, 8'h00, 1, "R4 R10 full protection refuses");
    step(0, 0, 1, 0, 16'h0000, 8'h00, 0, "R5 R10 pin lock refuses status write");
    step(0, 0, 1, 0, 16'h0000, 8'h04, 1, "R5 pin high allows status write");
    step(1, 0, 0, 1, 16'h0000, 8'h00, 1, "R11 strobes during busy");
    idle(BUSY - 2, 1, "R7 busy period");
    step(0, 0, 0, 1, 16'h0000, 8'h00, 1, "R11 strobe on last busy cycle");

    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 0, 1, 16'hBFFF, 8'h00, 1, "R4 level 01 below range");
    idle(BUSY, 1, "R7 R9 busy period");
    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 0, 1, 16'hC000, 8'h00, 1, "R4 level 01 in range");
    step(0, 0, 1, 0, 16'h0000, 8'h88, 0, "R5 lock off allows status write");
    idle(BUSY, 0, "R8 busy period");

    step(1, 0, 0, 0, 16'h0000, 8'h00, 0, "R2 set latch");
    step(0, 0, 0, 1, 16'h7FFF, 8'h00, 0, "R4 level 10 below range");
    idle(BUSY, 0, "R7 busy period");
    step(1, 0, 0, 0, 16'h0000, 8'h00, 0, "R2 set latch");
    step(0, 0, 0, 1, 16'h8000, 8'h00, 1, "R4 level 10 in range pin high");
    step(0, 0, 1, 0, 16'h0000, 8'h00, 1, "R5 pin high with lock set");
    idle(BUSY, 1, "R9 busy period");

    step(1, 0, 0, 0, 16'h0000, 8'h00, 1, "R2 set latch");
    step(0, 0, 1, 1, 16'h0000, 8'h08, 1, "R12 status write beats array write");
    idle(BUSY, 1, "R12 busy period");
    step(1, 0, 1, 0, 16'h0000, 8'h00, 1, "R12 set beats status write");
    idle(2, 1, "R12 settle");

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule